// File: doc/BRIEF.md
# Pulse-Width Timer Channel with Controlled Stop

This block is one timer channel fixed to pulse-width output. Once started, it drives a repeating pulse on one output. Each period lasts 2^CNT_W - 1 count-source strobes. The output is high for a programmable number of strobes at the head of every period and low for the rest. Software starts the channel by writing the run bit. When trigger gating is enabled, the channel arms on that write and begins only when the trigger input is seen high.

An interrupt request flag is raised when each pulse ends. It is also raised when the channel is switched into pulse-width mode from the timer or event-counter mode. The flag stays set until it is cleared.

Clearing the run bit halts the channel at once. If the output was high at that moment, it is pulled low and the flag is raised. If the output was already low, neither the output nor the flag changes.

An active-low cutoff input, when enabled, withdraws the output driver so that the pin can float.

Top module: `pwm_safe_stop_timer`

## Requirements
- R1: After reset, pwm_out is 0, irq is 0, pwm_drive_en is 1, the mode is timer (code 0) and the channel is idle.
- R2: A write to the control word (wr_addr 1; wr_data[1:0] mode, with 0 timer, 1 event, 2 one-shot and 3 pulse-width; wr_data[2] trigger gating; wr_data[3] cutoff enable) is ignored while the run bit is 1.
- R3: A control write that changes the mode to 3 from mode 0 or mode 1 sets irq one clock later.
- R4: With mode 3 and trigger gating off, writing 1 to the run bit (wr_addr 2, wr_data[0]) makes pwm_out high one clock later if the high time is non-zero. The output stays high for exactly high-time strobes, and the period is 2^CNT_W - 1 strobes.
- R5: With trigger gating on, writing the run bit only arms the channel. pwm_out rises one clock after the first clock on which trig_in is 1 while armed.
- R6: Every falling edge of pwm_out sets irq on the same clock. irq_clr clears irq one clock later, and a simultaneous set wins.
- R7: A high-time value (wr_addr 0) written while running is applied from the start of the next period.
- R8: A high time of 0 keeps pwm_out low and raises no request.
- R9: Writing 0 to the run bit while pwm_out is high makes pwm_out low and sets irq one clock later.
- R10: Writing 0 to the run bit while pwm_out is low stops counting and leaves pwm_out low and irq unchanged.
- R11: When cutoff is enabled and cut_n is 0, pwm_drive_en is 0. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 high time, 1 control, 2 run |
| wr_data | input | CNT_W | Write data |
| tick | input | 1 | Count-source strobe |
| trig_in | input | 1 | Start trigger, used when gating is enabled |
| cut_n | input | 1 | Cutoff request, active low |
| irq_clr | input | 1 | Clears the request flag |
| pwm_out | output | 1 | Pulse output level |
| pwm_drive_en | output | 1 | Output driver enable; 0 means high impedance |
| irq | output | 1 | Interrupt request flag |

## Verification
Register writes, strobes and trigger samples all take effect on a clock edge. Their effect on pwm_out and irq is due exactly one clock after that edge. The bench therefore drives each stimulus after a falling edge and compares at the next falling edge.

pwm_drive_en is combinational in cut_n, so its checks are taken 1 ns after cut_n changes. A bench-side model updated on every rising edge gives the expected output and flag for every cycle of both the directed and the random phases.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

   typedef enum logic [1:0] {
      MD_TIMER   = 2'd0,
      MD_EVENT   = 2'd1,
      MD_ONESHOT = 2'd2,
      MD_PWM     = 2'd3
   } chan_mode_e;

   typedef struct packed {
      logic       cut_en;
      logic       trig_en;
      chan_mode_e mode;
   } chan_ctrl_t;

   localparam logic [1:0] ADR_HIGH = 2'd0;
   localparam logic [1:0] ADR_CTRL = 2'd1;
   localparam logic [1:0] ADR_RUN  = 2'd2;

   localparam int CTRL_BITS = $bits(chan_ctrl_t);

endpackage

// File: rtl/pwmg_regs.sv
module pwmg_regs
   import pwmg_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] hi_shadow,
   output chan_ctrl_t   ctrl_q,
   output logic         run_q,
   output logic         run_set,
   output logic         run_clr,
   output logic         pwm_select
);

   logic       ctrl_wr;
   logic       ctrl_take;
   chan_ctrl_t ctrl_new;

   assign ctrl_wr   = wr_en && (wr_addr == ADR_CTRL);
   assign ctrl_take = ctrl_wr && !run_q;
   assign ctrl_new  = chan_ctrl_t'(wr_data[CTRL_BITS-1:0]);
   assign run_set   = wr_en && (wr_addr == ADR_RUN) &&  wr_data[0];
   assign run_clr   = wr_en && (wr_addr == ADR_RUN) && !wr_data[0];

   // entering pulse-width mode from timer or event counting raises a request
   assign pwm_select = ctrl_take && (ctrl_new.mode == MD_PWM) &&
                       ((ctrl_q.mode == MD_TIMER) || (ctrl_q.mode == MD_EVENT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_shadow <= '0;
         ctrl_q    <= '{cut_en: 1'b0, trig_en: 1'b0, mode: MD_TIMER};
         run_q     <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == ADR_HIGH)) hi_shadow <= wr_data;
         if (ctrl_take)                      ctrl_q    <= ctrl_new;
         if (run_set)                        run_q     <= 1'b1;
         else if (run_clr)                   run_q     <= 1'b0;
      end
   end

   assert_ctrl_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && run_q) |=> $stable(ctrl_q));

endmodule

// File: rtl/pwmg_core.sv
module pwmg_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hi_shadow,
   input  logic         is_pwm,
   input  logic         trig_en,
   input  logic         run_q,
   input  logic         run_set,
   input  logic         run_clr,
   input  logic         tick,
   input  logic         trig_in,
   output logic         out_q,
   output logic         active,
   output logic         fall
);

   localparam logic [W-1:0] LAST = {{(W-1){1'b1}}, 1'b0};

   logic [W-1:0] cnt_q, cnt_nx;
   logic [W-1:0] hi_cur, hi_nx;
   logic         act_nx, out_nx;
   logic         launch;
   logic         wrap;

   assign launch = !active && is_pwm &&
                   ((run_set && !trig_en) || (run_q && trig_en && trig_in));
   assign wrap   = active && tick && (cnt_q == LAST);

   always_comb begin
      cnt_nx = cnt_q;
      hi_nx  = hi_cur;
      act_nx = active;
      out_nx = out_q;
      if (run_clr) begin
         act_nx = 1'b0;
         cnt_nx = '0;
         out_nx = 1'b0;
      end else if (launch) begin
         act_nx = 1'b1;
         cnt_nx = '0;
         hi_nx  = hi_shadow;
         out_nx = (hi_shadow != '0);
      end else if (wrap) begin
         cnt_nx = '0;
         hi_nx  = hi_shadow;
         out_nx = (hi_shadow != '0);
      end else if (active && tick) begin
         cnt_nx = cnt_q + 1'b1;
         out_nx = (cnt_nx < hi_cur);
      end
   end

   assign fall = out_q && !out_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hi_cur <= '0;
         active <= 1'b0;
         out_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_nx;
         hi_cur <= hi_nx;
         active <= act_nx;
         out_q  <= out_nx;
      end
   end

   assert_stop_drops_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_clr && out_q) |=> !out_q);

   assert_zero_high_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cur == '0) |-> !out_q);

   assert_out_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |-> active);

   assert_high_held_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !wrap && !run_clr) |=> $stable(hi_cur));

endmodule

// File: rtl/pwmg_irq.sv
module pwmg_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic fall,
   input  logic pwm_select,
   input  logic irq_clr,
   output logic irq_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  irq_q <= 1'b0;
      else if (fall || pwm_select) irq_q <= 1'b1;
      else if (irq_clr)            irq_q <= 1'b0;
   end

   assert_fall_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> irq_q);

   assert_select_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_select |=> irq_q);

   assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && !pwm_select && !irq_clr) |=> $stable(irq_q));

endmodule

// File: rtl/pwm_safe_stop_timer.sv
module pwm_safe_stop_timer
   import pwmg_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int CUT_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   input  logic             trig_in,
   input  logic             cut_n,
   input  logic             irq_clr,
   output logic             pwm_out,
   output logic             pwm_drive_en,
   output logic             irq
);

   generate
      if (CNT_W < CTRL_BITS || CNT_W > 32) begin : g_bad_width
         $error("CNT_W must lie between CTRL_BITS and 32");
      end
      if (CUT_SYNC != 0 && CUT_SYNC != 1) begin : g_bad_sync
         $error("CUT_SYNC must be 0 or 1");
      end
   endgenerate

   logic [CNT_W-1:0] hi_shadow;
   chan_ctrl_t       ctrl_q;
   logic             run_q, run_set, run_clr, pwm_select;
   logic             active, fall;
   logic             cut_seen;

   pwmg_regs #(.W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .hi_shadow  (hi_shadow),
      .ctrl_q     (ctrl_q),
      .run_q      (run_q),
      .run_set    (run_set),
      .run_clr    (run_clr),
      .pwm_select (pwm_select)
   );

   pwmg_core #(.W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .hi_shadow (hi_shadow),
      .is_pwm    (ctrl_q.mode == MD_PWM),
      .trig_en   (ctrl_q.trig_en),
      .run_q     (run_q),
      .run_set   (run_set),
      .run_clr   (run_clr),
      .tick      (tick),
      .trig_in   (trig_in),
      .out_q     (pwm_out),
      .active    (active),
      .fall      (fall)
   );

   pwmg_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall       (fall),
      .pwm_select (pwm_select),
      .irq_clr    (irq_clr),
      .irq_q      (irq)
   );

   generate
      if (CUT_SYNC == 1) begin : g_cut_sync
         logic [1:0] cut_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cut_ff <= 2'b11;
            else        cut_ff <= {cut_ff[0], cut_n};
         end
         assign cut_seen = !cut_ff[1];
      end else begin : g_cut_direct
         assign cut_seen = !cut_n;
      end
   endgenerate

   assign pwm_drive_en = !(ctrl_q.cut_en && cut_seen);

endmodule

// File: tb/pwm_safe_stop_timer_test.sv
module pwm_safe_stop_timer_test;

   localparam int W      = 6;
   localparam int PERIOD = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         tick = 1'b0, trig_in = 1'b0, cut_n = 1'b1, irq_clr = 1'b0;
   logic         pwm_out, pwm_drive_en, irq;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pwm_safe_stop_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .trig_in(trig_in), .cut_n(cut_n),
      .irq_clr(irq_clr), .pwm_out(pwm_out), .pwm_drive_en(pwm_drive_en),
      .irq(irq)
   );

   // bench-side expected state, built from the requirements
   logic         m_run, m_trg, m_act, m_out, m_irq;
   logic [1:0]   m_mode;
   logic [W-1:0] m_hsh, m_hi;
   int           m_pos;

   function automatic logic level_at(int pos, logic [W-1:0] high);
      return pos < int'(high);
   endfunction

   always @(posedge clk) begin
      logic ev, stp, sta, go, old_out;
      if (!rst_n) begin
         m_run = 0; m_trg = 0; m_act = 0; m_out = 0; m_irq = 0;
         m_mode = 2'd0; m_hsh = '0; m_hi = '0; m_pos = 0;
      end else begin
         old_out = m_out;
         stp = wr_en && wr_addr == 2'd2 && !wr_data[0];
         sta = wr_en && wr_addr == 2'd2 &&  wr_data[0];
         go  = !m_act && m_mode == 2'd3 &&
               ((sta && !m_trg) || (m_run && m_trg && trig_in));
         ev  = 0;
         if (stp) begin
            m_act = 0; m_pos = 0; m_out = 0;
         end else if (go) begin
            m_act = 1; m_pos = 0; m_hi = m_hsh; m_out = level_at(0, m_hsh);
         end else if (m_act && tick) begin
            m_pos = (m_pos + 1) % PERIOD;
            if (m_pos == 0) m_hi = m_hsh;
            m_out = level_at(m_pos, m_hi);
         end
         if (wr_en && wr_addr == 2'd1 && !m_run) begin
            ev = wr_data[1:0] == 2'd3 && (m_mode == 2'd0 || m_mode == 2'd1);
            m_mode = wr_data[1:0];
            m_trg  = wr_data[2];
         end
         if (wr_en && wr_addr == 2'd0) m_hsh = wr_data;
         if (wr_en && wr_addr == 2'd2) m_run = wr_data[0];
         if ((old_out && !m_out) || ev) m_irq = 1;
         else if (irq_clr)              m_irq = 0;
      end
   end

   // every-cycle comparison against the expected state
   always @(negedge clk) begin
      if (rst_n) begin
         n_vec++;
         if (pwm_out !== m_out || irq !== m_irq) begin
            n_bad++;
            $display("FAIL R4 R6 R7 model: out=%0b irq=%0b expected out=%0b irq=%0b at %0t",
                     pwm_out, irq, m_out, m_irq, $time);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic we, input logic [1:0] a, input logic [W-1:0] d,
                      input logic tk, input logic tg, input logic cl);
      wr_en = we; wr_addr = a; wr_data = d; tick = tk; trig_in = tg; irq_clr = cl;
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; tick = 0; trig_in = 0; irq_clr = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      cyc(1, a, d, 0, 0, 0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(0, 2'd0, '0, 1, 0, 0);
   endtask

   task automatic clear_irq();
      cyc(0, 2'd0, '0, 0, 0, 1);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(pwm_out, 0, "R1 out");
      chk(irq, 0, "R1 irq");
      chk(pwm_drive_en, 1, "R1 drive");

      wr(2'd1, 6'b000011);
      chk(irq, 1, "R3 select from timer");
      clear_irq();
      chk(irq, 0, "R6 clear");

      wr(2'd0, 6'd5);
      wr(2'd2, 6'd1);
      chk(pwm_out, 1, "R4 start");
      ticks(4);
      chk(pwm_out, 1, "R4 still high");
      ticks(1);
      chk(pwm_out, 0, "R4 high time");
      chk(irq, 1, "R6 fall sets");
      clear_irq();
      ticks(PERIOD - 6);
      chk(pwm_out, 0, "R4 low tail");
      ticks(1);
      chk(pwm_out, 1, "R4 period");

      wr(2'd0, 6'd10);
      ticks(5);
      chk(pwm_out, 0, "R7 old value kept");
      clear_irq();
      ticks(PERIOD - 5);
      chk(pwm_out, 1, "R7 new period");
      ticks(9);
      chk(pwm_out, 1, "R7 new high");
      ticks(1);
      chk(pwm_out, 0, "R7 new fall");
      clear_irq();

      wr(2'd2, 6'd0);
      chk(pwm_out, 0, "R10 out");
      chk(irq, 0, "R10 irq");

      wr(2'd2, 6'd1);
      chk(pwm_out, 1, "R9 restart");
      ticks(3);
      wr(2'd2, 6'd0);
      chk(pwm_out, 0, "R9 out");
      chk(irq, 1, "R9 irq");
      clear_irq();

      wr(2'd2, 6'd1);
      wr(2'd1, 6'b000000);
      wr(2'd2, 6'd0);
      clear_irq();
      wr(2'd2, 6'd1);
      chk(pwm_out, 1, "R2 mode kept");
      wr(2'd2, 6'd0);
      clear_irq();

      wr(2'd0, 6'd0);
      wr(2'd2, 6'd1);
      chk(pwm_out, 0, "R8 start");
      ticks(2 * PERIOD + 4);
      chk(pwm_out, 0, "R8 out");
      chk(irq, 0, "R8 irq");
      wr(2'd2, 6'd0);

      wr(2'd1, 6'b000111);
      chk(irq, 0, "R3 no select from pwm");
      wr(2'd0, 6'd4);
      wr(2'd2, 6'd1);
      chk(pwm_out, 0, "R5 armed");
      ticks(10);
      chk(pwm_out, 0, "R5 waiting");
      cyc(0, 2'd0, '0, 0, 1, 0);
      chk(pwm_out, 1, "R5 triggered");
      ticks(4);
      chk(pwm_out, 0, "R5 fall");
      chk(irq, 1, "R6 fall after trigger");
      clear_irq();
      wr(2'd2, 6'd0);

      wr(2'd1, 6'b001011);
      cut_n = 0; #1;
      chk(pwm_drive_en, 0, "R11 cutoff");
      cut_n = 1; #1;
      chk(pwm_drive_en, 1, "R11 release");
      wr(2'd1, 6'b000011);
      cut_n = 0; #1;
      chk(pwm_drive_en, 1, "R11 disabled");
      cut_n = 1;
      @(negedge clk);

      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [1:0] a;
         logic [W-1:0] d;
         r = int'($urandom_range(0, 99));
         a = 2'd0; d = W'($urandom_range(0, PERIOD));
         if (r < 3)       begin a = 2'd1; d = W'($urandom_range(0, 7)); end
         else if (r < 6)  begin a = 2'd2; d = W'($urandom_range(0, 1)); end
         else if (r < 8)  begin a = 2'd1; d = 6'b000011; end
         cyc(r < 10, a, d, $urandom_range(0, 1) == 1,
             $urandom_range(0, 19) == 0, $urandom_range(0, 9) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule